// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch status of every hardware thread of a multithreaded front end and recomputes it on each clock from the control traffic that comes back from the later pipeline stages. Each thread has its own state register and its own fetch address registers (current, next and next-next PC). A squash loads a redirect address into those registers. A downstream stall parks the thread. The instruction-cache handshake, translation faults and quiesce requests walk the thread through their waiting states.

The later stages report congestion with block and unblock pulses. The block keeps one sticky stall bit per stage and per thread, so a stage only has to signal the edges of its stall. A global context-switch input stalls every thread. The incoming signals are evaluated in a fixed order: a commit squash first, then the reorder buffer still flushing, then a decode squash, then a stall. The front end reads `active_o` to decide whether the fetch stage has any useful work this cycle. It reads `changed_o` to learn that some thread moved.

Top module: `fetch_status_ctl`

## Requirements
- R1: While reset is held and after it is released, every thread's state is RUN. The state code is 4 bits per thread, thread t at `state_o[4t+3:4t]`, with the codes RUN=0, IDLE=1, FLUSH=2, HOLD=3, MEMWAIT=4, MEMRETRY=5, MEMDONE=6, TRAP=7, SLEEP=8. After reset, pc = RESET_PC, npc = RESET_PC+4 and nnpc = RESET_PC+8; `changed_o` and `proto_err_o` are 0.
- R2: A commit squash on a thread wins over every other input of that thread. One clock later the thread is in FLUSH, with pc = redirect, npc = redirect+4 and nnpc = redirect+8. Other threads are not affected.
- R3: When the reorder buffer of a thread is still flushing and there is no commit squash, the thread is in FLUSH on the next clock and its PC registers keep their values.
- R4: A decode squash redirects the PC registers (same offsets as R2) and enters FLUSH only if the thread is not already in FLUSH. In FLUSH it is ignored: the PCs keep their values and evaluation continues with the stall check.
- R5: Each thread has one sticky stall bit per stage. Stage s of thread t sits at bit 4t+s of the block and unblock inputs, in the order 0 decode, 1 rename, 2 execute, 3 commit. A block pulse sets the bit. An unblock pulse clears it, and it also clears it when both arrive together. The thread is stalled if any of its bits is set after this cycle's update, or if the context-switch input is high. A stalled thread with no squash goes to HOLD, except from MEMWAIT, MEMRETRY, TRAP or SLEEP.
- R6: A thread in HOLD or FLUSH that sees no squash and is not stalled returns to RUN.
- R7: Cache handshake. From RUN, a refused request goes to MEMRETRY and a sent request goes to MEMWAIT. From MEMRETRY, a retry grant goes to MEMWAIT. From MEMWAIT, a fill completion goes to MEMDONE, or to HOLD if the thread is stalled. From MEMDONE, being selected for fetch goes to RUN. A fill completion in any other state is ignored.
- R8: From RUN, a translation fault goes to TRAP and a quiesce goes to SLEEP. The order of precedence is fault, then quiesce, then refused, then sent.
- R9: TRAP is left only through a squash (R2, R3 or R4). SLEEP is left through a squash or through the wake input, which moves it to RUN. Stalls and wake have no effect in TRAP.
- R10: A thread in RUN whose active bit is low moves to IDLE, and this takes precedence over all RUN events. A thread in IDLE returns to RUN when its active bit is high.
- R11: `active_o` is combinational. It is 1 exactly when some thread whose active bit is high is in RUN, FLUSH or MEMDONE.
- R12: `changed_o` is 1 during the clock cycle that follows an edge at which any thread's state changed, and 0 otherwise.
- R13: `proto_err_o` is 1 for one cycle after either an unblock pulse for a stage whose stall bit is clear, or a block and an unblock for the same stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_act_i | input | NUM_THREADS | Thread is active (scheduled) |
| stage_block_i | input | NUM_THREADS*NUM_STAGES | Block pulses, bit t*NUM_STAGES+s |
| stage_unblock_i | input | NUM_THREADS*NUM_STAGES | Unblock pulses, same layout |
| ctx_switch_i | input | 1 | Global context-switch stall |
| commit_squash_i | input | NUM_THREADS | Squash from commit |
| commit_pc_i | input | NUM_THREADS*PC_W | Commit redirect address per thread |
| rob_flushing_i | input | NUM_THREADS | Reorder buffer still squashing |
| decode_squash_i | input | NUM_THREADS | Squash from decode |
| decode_pc_i | input | NUM_THREADS*PC_W | Decode redirect address per thread |
| req_sent_i | input | NUM_THREADS | Cache line request accepted |
| req_refused_i | input | NUM_THREADS | Cache line request refused, retry later |
| retry_ok_i | input | NUM_THREADS | Refused request now accepted |
| fill_done_i | input | NUM_THREADS | Cache fill completed |
| fetch_sel_i | input | NUM_THREADS | Thread selected for fetch |
| xlate_fault_i | input | NUM_THREADS | Address translation fault |
| quiesce_i | input | NUM_THREADS | Quiesce request |
| wake_i | input | NUM_THREADS | Wake from quiesce |
| state_o | output | NUM_THREADS*4 | Per-thread state code |
| pc_o | output | NUM_THREADS*PC_W | Current fetch PC |
| npc_o | output | NUM_THREADS*PC_W | Next PC |
| nnpc_o | output | NUM_THREADS*PC_W | Next-next PC |
| changed_o | output | 1 | Some thread changed state at the last edge |
| active_o | output | 1 | Fetch stage has a running-like active thread |
| proto_err_o | output | 1 | Stall pulse protocol violation at the last edge |

## Verification
A wrong stall bit cannot be read directly. It shows only when the thread next leaves FLUSH or HOLD: it goes to HOLD instead of RUN, or the other way round, and `active_o` flips in the same cycle. The stimulus therefore sets a bit in a cycle where a squash masks it, and checks the effect one clock later. A wrong priority between the squash sources shows one clock after the conflicting inputs, in the state code and in the PC registers. A wrong exit from TRAP or SLEEP shows in the state code at the next edge.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   localparam int STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      FS_RUN      = 4'd0,
      FS_IDLE     = 4'd1,
      FS_FLUSH    = 4'd2,
      FS_HOLD     = 4'd3,
      FS_MEMWAIT  = 4'd4,
      FS_MEMRETRY = 4'd5,
      FS_MEMDONE  = 4'd6,
      FS_TRAP     = 4'd7,
      FS_SLEEP    = 4'd8
   } fstate_e;

   // events that only matter once the priority chain falls through
   typedef struct packed {
      logic sent;
      logic refused;
      logic retry_ok;
      logic done;
      logic sel;
      logic fault;
      logic quiesce;
      logic wake;
   } fetch_ev_t;

   // states that count toward stage activity
   function automatic logic is_live(fstate_e s);
      return (s == FS_RUN) || (s == FS_FLUSH) || (s == FS_MEMDONE);
   endfunction

   // states a stall cannot pull into HOLD
   function automatic logic stall_exempt(fstate_e s);
      return (s == FS_MEMWAIT) || (s == FS_MEMRETRY) ||
             (s == FS_TRAP) || (s == FS_SLEEP);
   endfunction

endpackage

// File: rtl/fsc_stall_track.sv
module fsc_stall_track #(
   parameter int NUM_STAGES   = 4,
   parameter bit UNBLOCK_WINS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STAGES-1:0] blk_i,
   input  logic [NUM_STAGES-1:0] unblk_i,
   input  logic                  ctx_i,
   output logic                  stalled_o,
   output logic                  err_o
);

   logic [NUM_STAGES-1:0] bits_q;
   logic [NUM_STAGES-1:0] bits_n;

   generate
      if (UNBLOCK_WINS) begin : g_unblk_wins
         assign bits_n = (bits_q | blk_i) & ~unblk_i;
      end else begin : g_blk_wins
         assign bits_n = (bits_q & ~unblk_i) | blk_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_n;
   end

   // the updated bits take effect in the cycle the pulse arrives
   assign stalled_o = (|bits_n) | ctx_i;
   assign err_o     = |(unblk_i & (~bits_q | blk_i));

   AST_UNBLOCK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctx_i && !(|blk_i) && (unblk_i == bits_q) && UNBLOCK_WINS) |-> !stalled_o)
      else $error("unblock of all set stages left a stall"); // R5

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
   import fsc_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter int          INST_BYTES = 4,
   parameter logic [63:0] RESET_PC   = 64'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_i,
   input  logic            cmt_sq_i,
   input  logic [PC_W-1:0] cmt_pc_i,
   input  logic            rob_sq_i,
   input  logic            dec_sq_i,
   input  logic [PC_W-1:0] dec_pc_i,
   input  logic            stalled_i,
   input  fetch_ev_t       ev_i,
   output fstate_e         state_o,
   output logic [PC_W-1:0] pc_o,
   output logic [PC_W-1:0] npc_o,
   output logic [PC_W-1:0] nnpc_o,
   output logic            chg_o
);

   localparam logic [PC_W-1:0] STEP1 = PC_W'(INST_BYTES);
   localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INST_BYTES);
   localparam logic [PC_W-1:0] PC0   = PC_W'(RESET_PC);

   fstate_e         st_q, st_n;
   logic            load;
   logic [PC_W-1:0] tgt;
   logic [PC_W-1:0] pc_q, npc_q, nnpc_q;

   always_comb begin
      st_n = st_q;
      load = 1'b0;
      tgt  = cmt_pc_i;
      if (cmt_sq_i) begin
         st_n = FS_FLUSH;
         load = 1'b1;
      end else if (rob_sq_i) begin
         st_n = FS_FLUSH;
      end else if (dec_sq_i && st_q != FS_FLUSH) begin
         st_n = FS_FLUSH;
         load = 1'b1;
         tgt  = dec_pc_i;
      end else if (stalled_i && !stall_exempt(st_q)) begin
         st_n = FS_HOLD;
      end else if (st_q == FS_HOLD || st_q == FS_FLUSH) begin
         st_n = FS_RUN;
      end else begin
         case (st_q)
            FS_RUN: begin
               if (!act_i)              st_n = FS_IDLE;
               else if (ev_i.fault)     st_n = FS_TRAP;
               else if (ev_i.quiesce)   st_n = FS_SLEEP;
               else if (ev_i.refused)   st_n = FS_MEMRETRY;
               else if (ev_i.sent)      st_n = FS_MEMWAIT;
            end
            FS_IDLE:     if (act_i)         st_n = FS_RUN;
            FS_MEMRETRY: if (ev_i.retry_ok) st_n = FS_MEMWAIT;
            FS_MEMWAIT:  if (ev_i.done)     st_n = stalled_i ? FS_HOLD : FS_MEMDONE;
            FS_MEMDONE:  if (ev_i.sel)      st_n = FS_RUN;
            FS_SLEEP:    if (ev_i.wake)     st_n = FS_RUN;
            default:     st_n = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_RUN;
         pc_q   <= PC0;
         npc_q  <= PC0 + STEP1;
         nnpc_q <= PC0 + STEP2;
      end else begin
         st_q <= st_n;
         if (load) begin
            pc_q   <= tgt;
            npc_q  <= tgt + STEP1;
            nnpc_q <= tgt + STEP2;
         end
      end
   end

   assign state_o = st_q;
   assign pc_o    = pc_q;
   assign npc_o   = npc_q;
   assign nnpc_o  = nnpc_q;
   assign chg_o   = (st_n != st_q);

   AST_COMMIT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_sq_i |=> (st_q == FS_FLUSH) && (pc_q == $past(cmt_pc_i)))
      else $error("commit squash not taken"); // R2

   AST_ROB_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_sq_i && !cmt_sq_i) |=> (st_q == FS_FLUSH) && $stable(pc_q))
      else $error("reorder flush moved the PC"); // R3

   AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_TRAP && !cmt_sq_i && !rob_sq_i && !dec_sq_i) |=> (st_q == FS_TRAP))
      else $error("trap left without squash"); // R9

   AST_STALL_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled_i && !cmt_sq_i && !rob_sq_i && !(dec_sq_i && st_q != FS_FLUSH) &&
       (st_q inside {FS_RUN, FS_IDLE, FS_HOLD, FS_FLUSH, FS_MEMDONE})) |=> (st_q == FS_HOLD))
      else $error("stall did not park the thread"); // R5

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
   import fsc_pkg::*;
#(
   parameter int NUM_THREADS = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THREADS*STATE_W-1:0] state_vec_i,
   input  logic [NUM_THREADS-1:0]         act_i,
   input  logic [NUM_THREADS-1:0]         chg_i,
   input  logic [NUM_THREADS-1:0]         err_i,
   output logic                           active_o,
   output logic                           changed_o,
   output logic                           err_o
);

   logic [NUM_THREADS-1:0] live;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_live
         assign live[t] = act_i[t] & is_live(fstate_e'(state_vec_i[t*STATE_W +: STATE_W]));
      end
   endgenerate

   assign active_o = |live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         changed_o <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         changed_o <= |chg_i;
         err_o     <= |err_i;
      end
   end

   AST_NO_ACTIVE_THREADS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == '0) |-> !active_o)
      else $error("stage active with no active thread"); // R11

endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
   import fsc_pkg::*;
#(
   parameter int          NUM_THREADS  = 2,
   parameter int          NUM_STAGES   = 4,
   parameter int          PC_W         = 32,
   parameter int          INST_BYTES   = 4,
   parameter bit          UNBLOCK_WINS = 1'b1,
   parameter logic [63:0] RESET_PC     = 64'h0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THREADS-1:0]         thread_act_i,
   input  logic [NUM_THREADS*NUM_STAGES-1:0] stage_block_i,
   input  logic [NUM_THREADS*NUM_STAGES-1:0] stage_unblock_i,
   input  logic                           ctx_switch_i,
   input  logic [NUM_THREADS-1:0]         commit_squash_i,
   input  logic [NUM_THREADS*PC_W-1:0]    commit_pc_i,
   input  logic [NUM_THREADS-1:0]         rob_flushing_i,
   input  logic [NUM_THREADS-1:0]         decode_squash_i,
   input  logic [NUM_THREADS*PC_W-1:0]    decode_pc_i,
   input  logic [NUM_THREADS-1:0]         req_sent_i,
   input  logic [NUM_THREADS-1:0]         req_refused_i,
   input  logic [NUM_THREADS-1:0]         retry_ok_i,
   input  logic [NUM_THREADS-1:0]         fill_done_i,
   input  logic [NUM_THREADS-1:0]         fetch_sel_i,
   input  logic [NUM_THREADS-1:0]         xlate_fault_i,
   input  logic [NUM_THREADS-1:0]         quiesce_i,
   input  logic [NUM_THREADS-1:0]         wake_i,
   output logic [NUM_THREADS*4-1:0]       state_o,
   output logic [NUM_THREADS*PC_W-1:0]    pc_o,
   output logic [NUM_THREADS*PC_W-1:0]    npc_o,
   output logic [NUM_THREADS*PC_W-1:0]    nnpc_o,
   output logic                           changed_o,
   output logic                           active_o,
   output logic                           proto_err_o
);

   localparam int SW = STATE_W;

   generate
      if (NUM_THREADS < 1) begin : g_chk_thr
         $error("NUM_THREADS must be at least 1");
      end
      if (NUM_STAGES < 1) begin : g_chk_stg
         $error("NUM_STAGES must be at least 1");
      end
      if (PC_W < 8) begin : g_chk_pc
         $error("PC_W must be at least 8");
      end
      if (INST_BYTES < 1 || (INST_BYTES & (INST_BYTES - 1)) != 0) begin : g_chk_ib
         $error("INST_BYTES must be a power of two");
      end
   endgenerate

   logic [NUM_THREADS*SW-1:0] st_vec;
   logic [NUM_THREADS-1:0]    chg_vec;
   logic [NUM_THREADS-1:0]    err_vec;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         logic      stalled;
         fstate_e   st;
         fetch_ev_t ev;

         assign ev = '{sent:     req_sent_i[t],
                       refused:  req_refused_i[t],
                       retry_ok: retry_ok_i[t],
                       done:     fill_done_i[t],
                       sel:      fetch_sel_i[t],
                       fault:    xlate_fault_i[t],
                       quiesce:  quiesce_i[t],
                       wake:     wake_i[t]};

         fsc_stall_track #(
            .NUM_STAGES  (NUM_STAGES),
            .UNBLOCK_WINS(UNBLOCK_WINS)
         ) i_stall (
            .clk      (clk),
            .rst_n    (rst_n),
            .blk_i    (stage_block_i[t*NUM_STAGES +: NUM_STAGES]),
            .unblk_i  (stage_unblock_i[t*NUM_STAGES +: NUM_STAGES]),
            .ctx_i    (ctx_switch_i),
            .stalled_o(stalled),
            .err_o    (err_vec[t])
         );

         fsc_thread_fsm #(
            .PC_W      (PC_W),
            .INST_BYTES(INST_BYTES),
            .RESET_PC  (RESET_PC)
         ) i_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (thread_act_i[t]),
            .cmt_sq_i (commit_squash_i[t]),
            .cmt_pc_i (commit_pc_i[t*PC_W +: PC_W]),
            .rob_sq_i (rob_flushing_i[t]),
            .dec_sq_i (decode_squash_i[t]),
            .dec_pc_i (decode_pc_i[t*PC_W +: PC_W]),
            .stalled_i(stalled),
            .ev_i     (ev),
            .state_o  (st),
            .pc_o     (pc_o[t*PC_W +: PC_W]),
            .npc_o    (npc_o[t*PC_W +: PC_W]),
            .nnpc_o   (nnpc_o[t*PC_W +: PC_W]),
            .chg_o    (chg_vec[t])
         );

         assign st_vec[t*SW +: SW] = st;
      end
   endgenerate

   assign state_o = st_vec;

   fsc_activity #(
      .NUM_THREADS(NUM_THREADS)
   ) i_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_vec_i(st_vec),
      .act_i      (thread_act_i),
      .chg_i      (chg_vec),
      .err_i      (err_vec),
      .active_o   (active_o),
      .changed_o  (changed_o),
      .err_o      (proto_err_o)
   );

   AST_DOUBLE_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stage_block_i & stage_unblock_i)) |=> proto_err_o)
      else $error("same-cycle block and unblock not flagged"); // R13

endmodule

// File: tb/test_fetch_status_ctl.sv
`timescale 1ns/1ps
module test_fetch_status_ctl;

   localparam int NT = 2;
   localparam int NS = 4;
   localparam int PW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NT-1:0]    act, csq, rsq, dsq, snt, rfs, rok, dn, sel, flt, qsc, wak;
   logic [NT*NS-1:0] blk, unb;
   logic             ctx;
   logic [NT*PW-1:0] cpc, dpc;
   logic [NT*4-1:0]  st;
   logic [NT*PW-1:0] pc, npc, nnpc;
   logic             chg, actv, perr;

   fetch_status_ctl #(
      .NUM_THREADS(NT), .NUM_STAGES(NS), .PC_W(PW), .INST_BYTES(4),
      .UNBLOCK_WINS(1'b1), .RESET_PC(64'h100)
   ) i_fetch_status_ctl (
      .clk(clk), .rst_n(rst_n), .thread_act_i(act),
      .stage_block_i(blk), .stage_unblock_i(unb), .ctx_switch_i(ctx),
      .commit_squash_i(csq), .commit_pc_i(cpc), .rob_flushing_i(rsq),
      .decode_squash_i(dsq), .decode_pc_i(dpc), .req_sent_i(snt),
      .req_refused_i(rfs), .retry_ok_i(rok), .fill_done_i(dn),
      .fetch_sel_i(sel), .xlate_fault_i(flt), .quiesce_i(qsc), .wake_i(wak),
      .state_o(st), .pc_o(pc), .npc_o(npc), .nnpc_o(nnpc),
      .changed_o(chg), .active_o(actv), .proto_err_o(perr)
   );

   typedef struct packed {
      logic [3:0]  blk, unb;
      logic        csq, rsq, dsq, ctx, snt, rfs, rok, dn, sel, flt, qsc, wak, act;
      logic [15:0] rpc;
      logic [3:0]  est;
      logic [15:0] epc;
      logic        eerr, eact, echg;
   } vec_t;

   localparam int NV = 31;
   // fields: blk unb csq rsq dsq ctx snt rfs rok dn sel flt qsc wak act rpc | st pc err act chg
   localparam vec_t TBL [NV] = '{
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd4,16'h100,1'b0,1'b0,1'b1}, // 1  R7 sent
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd6,16'h100,1'b0,1'b1,1'b1}, // 2  R7 fill
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h100,1'b0,1'b1,1'b1}, // 3  R7 select
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd5,16'h100,1'b0,1'b0,1'b1}, // 4  R7 refused
      '{4'h1,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd5,16'h100,1'b0,1'b0,1'b0}, // 5  R5 exempt
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd4,16'h100,1'b0,1'b0,1'b1}, // 6  R7 retry
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd3,16'h100,1'b0,1'b0,1'b1}, // 7  R7 fill while stalled
      '{4'h0,4'h1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h100,1'b0,1'b1,1'b1}, // 8  R6
      '{4'h0,4'h1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h100,1'b1,1'b1,1'b0}, // 9  R13 stray unblock
      '{4'h4,4'h4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h100,1'b1,1'b1,1'b0}, // 10 R13 R5 both
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd3,16'h100,1'b0,1'b0,1'b1}, // 11 R5 context switch
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h100,1'b0,1'b1,1'b1}, // 12 R6
      '{4'h2,4'h0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,16'h200,4'd2,16'h200,1'b0,1'b1,1'b1}, // 13 R2 wins
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd3,16'h200,1'b0,1'b0,1'b1}, // 14 R5 sticky
      '{4'h0,4'h2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h200,1'b0,1'b1,1'b1}, // 15 R6
      '{4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h300,4'd2,16'h300,1'b0,1'b1,1'b1}, // 16 R4
      '{4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h400,4'd0,16'h300,1'b0,1'b1,1'b1}, // 17 R4 ignored
      '{4'h0,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd2,16'h300,1'b0,1'b1,1'b1}, // 18 R3
      '{4'h0,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd2,16'h300,1'b0,1'b1,1'b0}, // 19 R3
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h300,1'b0,1'b1,1'b1}, // 20 R6
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,16'h0,  4'd7,16'h300,1'b0,1'b0,1'b1}, // 21 R8
      '{4'h8,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd7,16'h300,1'b0,1'b0,1'b0}, // 22 R9 stall ignored
      '{4'h0,4'h8,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0,  4'd7,16'h300,1'b0,1'b0,1'b0}, // 23 R9 wake ignored
      '{4'h0,4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h500,4'd2,16'h500,1'b0,1'b1,1'b1}, // 24 R9 squash exit
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h500,1'b0,1'b1,1'b1}, // 25 R6
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,16'h0,  4'd8,16'h500,1'b0,1'b0,1'b1}, // 26 R8 quiesce
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd8,16'h500,1'b0,1'b0,1'b0}, // 27 R7 stray fill
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0,  4'd0,16'h500,1'b0,1'b1,1'b1}, // 28 R9 wake
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,  4'd1,16'h500,1'b0,1'b0,1'b1}, // 29 R10
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0,  4'd1,16'h500,1'b0,1'b0,1'b0}, // 30 R10
      '{4'h0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0,  4'd0,16'h500,1'b0,1'b1,1'b1}  // 31 R10
   };

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic quiet();
      act = 2'b01; csq = '0; rsq = '0; dsq = '0; snt = '0; rfs = '0; rok = '0;
      dn = '0; sel = '0; flt = '0; qsc = '0; wak = '0; blk = '0; unb = '0;
      ctx = 1'b0; cpc = '0; dpc = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      quiet();
      repeat (3) @(negedge clk);
      // R1 reset values, held in reset
      chk("R1 state", 64'(st), 64'h0);
      chk("R1 pc t0", 64'(pc[PW-1:0]), 64'h100);
      chk("R1 pc t1", 64'(pc[2*PW-1:PW]), 64'h100);
      chk("R1 npc", 64'(npc[PW-1:0]), 64'h104);
      chk("R1 nnpc", 64'(nnpc[PW-1:0]), 64'h108);
      chk("R1 changed", 64'(chg), 64'h0);
      chk("R1 err", 64'(perr), 64'h0);
      chk("R11 active at reset", 64'(actv), 64'h1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         quiet();
         blk[3:0] = TBL[i].blk;  unb[3:0] = TBL[i].unb;
         csq[0] = TBL[i].csq;    rsq[0] = TBL[i].rsq;   dsq[0] = TBL[i].dsq;
         ctx    = TBL[i].ctx;    snt[0] = TBL[i].snt;   rfs[0] = TBL[i].rfs;
         rok[0] = TBL[i].rok;    dn[0]  = TBL[i].dn;    sel[0] = TBL[i].sel;
         flt[0] = TBL[i].flt;    qsc[0] = TBL[i].qsc;   wak[0] = TBL[i].wak;
         act[0] = TBL[i].act;
         cpc[PW-1:0] = PW'(TBL[i].rpc);
         dpc[PW-1:0] = PW'(TBL[i].rpc);
         tick();
         chk($sformatf("vec %0d state R5/R6/R7/R8/R9", i + 1), 64'(st[3:0]), 64'(TBL[i].est));
         chk($sformatf("vec %0d pc R2/R3/R4", i + 1), 64'(pc[PW-1:0]), 64'(TBL[i].epc));
         chk($sformatf("vec %0d R13 err", i + 1), 64'(perr), 64'(TBL[i].eerr));
         chk($sformatf("vec %0d R11 active", i + 1), 64'(actv), 64'(TBL[i].eact));
         chk($sformatf("vec %0d R12 changed", i + 1), 64'(chg), 64'(TBL[i].echg));
      end

      // R4 decode redirect offsets (from vector 24)
      chk("R4 npc", 64'(npc[PW-1:0]), 64'h504);
      chk("R4 nnpc", 64'(nnpc[PW-1:0]), 64'h508);
      // R10 inactive thread 1 parked in IDLE
      chk("R10 t1 idle", 64'(st[7:4]), 64'h1);

      // R12 quiet cycle, nothing moves
      quiet();
      tick();
      chk("R12 quiet", 64'(chg), 64'h0);

      // R2 commit squash on thread 1 only
      quiet();
      csq[1] = 1'b1;
      cpc[2*PW-1:PW] = 32'h1000;
      tick();
      chk("R2 t1 state", 64'(st[7:4]), 64'h2);
      chk("R2 t1 pc", 64'(pc[2*PW-1:PW]), 64'h1000);
      chk("R2 t1 npc", 64'(npc[2*PW-1:PW]), 64'h1004);
      chk("R2 t1 nnpc", 64'(nnpc[2*PW-1:PW]), 64'h1008);
      chk("R2 t0 untouched", 64'(pc[PW-1:0]), 64'h500);
      chk("R2 t0 state", 64'(st[3:0]), 64'h0);

      // R11 inactive thread in FLUSH does not count
      quiet();
      act = 2'b00;
      #1;
      chk("R11 no active thread", 64'(actv), 64'h0);

      // R5 stall bit of thread 1 leaves thread 0 alone
      quiet();
      blk[NS+1] = 1'b1;
      tick();
      chk("R5 t1 hold", 64'(st[7:4]), 64'h3);
      chk("R5 t0 run", 64'(st[3:0]), 64'h0);

      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule